// File: doc/BRIEF.md
# Hierarchical Power Domain Sequencer

This block switches a set of power domains and on-chip memory tiles in a safe order. Software loads two request words through a small write port: a domain word and a tile word. It then issues one start strobe. Every selected domain or tile whose requested state differs from its present state becomes part of one batch. The sequencer turns the switch enables on or off one at a time. After each change it waits for that switch to report the new state before it moves on.

Domains carry a fixed rank: index 0 is the topmost layer and each higher index sits one layer lower. All memory tiles belong to one owner domain and rank below every domain. Powering down runs from the bottom of the hierarchy upward, and powering up runs from the top downward. In a batch that mixes directions, every power-down step finishes before any power-up step starts. A request that would power the owner domain up without bringing up all of its tiles is refused as a whole.

Top module: `pwr_domain_seq`

## Requirements
- R1: Address 0 writes the domain word and address 1 writes the tile word. Writes that arrive while busy_o is high are ignored.
- R2: Domain d is selected by bit 24+d of the domain word and gets its target state from bit 8+d (1 = on). A domain that is not selected keeps its state.
- R3: Tile n is selected by bit 24+n of the tile word and gets its mode from bits [2n+1:2n]. Mode 2'b11 means on and 2'b00 means off. Modes 2'b01 and 2'b10 on a selected tile are invalid and make the request an error.
- R4: A start strobe while idle launches the whole batch. A start strobe while busy is ignored. The switch enables never change while idle without a start.
- R5: At most one switch enable changes per cycle. The next change waits until ack_i of the current switch equals its new enable value, or until the timeout expires.
- R6: Power-up steps go in ascending switch index: domain 0 first, then the other domains in turn, then tiles 0 upward.
- R7: Power-down steps go tiles first (ascending), then domains in descending index.
- R8: In a batch that mixes directions, all power-down steps complete before the first power-up step.
- R9: Entries that are unselected, or selected but already in the target state, take no cycles. The next switch changes in the same cycle the current acknowledge is seen, so consecutive steps are spaced exactly by the acknowledge latency.
- R10: If the owner domain (index 1) would go from off to on and any tile is not selected with mode 2'b11, or if any selected tile has an invalid mode, then no switch changes, busy_o stays low, err_o is set and done_o pulses in the next cycle.
- R11: If the acknowledge does not arrive within TMO_CYC cycles of a switch change (default 16), the sequence moves on to the next step and err_o is set.
- R12: busy_o is high from the cycle after an accepted start until the cycle after the last acknowledge. done_o then pulses for one cycle. An accepted start clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Request word write strobe |
| wr_addr_i | input | 1 | 0 = domain word, 1 = tile word |
| wr_data_i | input | 32 | Request word data |
| start_i | input | 1 | Launch the loaded batch |
| ack_i | input | N_DOM+N_TILE (10) | Reported state of each switch |
| sw_en_o | output | N_DOM+N_TILE (10) | Switch enables: domains in bits [N_DOM-1:0], tiles above them |
| busy_o | output | 1 | Batch in progress |
| done_o | output | 1 | One-cycle pulse at the end of a batch or a refused request |
| err_o | output | 1 | Last batch was refused or had a timeout |

## Verification
The acknowledge of one switch and the issue of the next are handled in the same cycle. The bench provokes this with a switch model that reflects each enable back after a fixed two-register delay. It then requires the spacing between consecutive enable changes to be exactly three cycles, including batches that contain selected entries with nothing to do. A second collision is a start strobe and a request-word write landing while a batch is running. The bench judges this by the finished enable pattern and by a follow-up start that must find nothing left to do.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int WORD_W   = 32;
  localparam int SEL_BASE = 24;
  localparam int ST_BASE  = 8;
  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_ON  = 2'b11;
  localparam logic ADDR_DOM  = 1'b0;
  localparam logic ADDR_TILE = 1'b1;
endpackage

// File: rtl/pwr_req_regs.sv
module pwr_req_regs
  import pwr_seq_pkg::*;
#(
  parameter int N_DOM     = 4,
  parameter int N_TILE    = 6,
  parameter int OWNER_DOM = 1,
  localparam int N_SW     = N_DOM + N_TILE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic [N_SW-1:0]   cur_i,
  output logic [N_SW-1:0]   sel_o,
  output logic [N_SW-1:0]   tgt_o,
  output logic              err_o
);
  logic [N_DOM-1:0]    dom_sel_q, dom_st_q;
  logic [N_TILE-1:0]   tile_sel_q;
  logic [2*N_TILE-1:0] tile_mode_q;
  logic [N_TILE-1:0]   tile_bad, tile_full;
  logic                unused_data;

  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dom_sel_q   <= '0;
      dom_st_q    <= '0;
      tile_sel_q  <= '0;
      tile_mode_q <= '0;
    end else if (wr_en_i && !busy_i) begin
      if (wr_addr_i == ADDR_DOM) begin
        dom_sel_q <= wr_data_i[SEL_BASE +: N_DOM];
        dom_st_q  <= wr_data_i[ST_BASE +: N_DOM];
      end else begin
        tile_sel_q  <= wr_data_i[SEL_BASE +: N_TILE];
        tile_mode_q <= wr_data_i[2*N_TILE-1:0];
      end
    end
  end

  assign sel_o[N_DOM-1:0] = dom_sel_q;
  assign tgt_o[N_DOM-1:0] = dom_st_q;

  for (genvar n = 0; n < N_TILE; n++) begin : g_tile
    logic [1:0] mode;
    assign mode             = tile_mode_q[2*n +: 2];
    assign sel_o[N_DOM+n]   = tile_sel_q[n];
    assign tgt_o[N_DOM+n]   = (mode == MODE_ON);
    assign tile_full[n]     = tile_sel_q[n] && (mode == MODE_ON);
    assign tile_bad[n]      = tile_sel_q[n] && (mode != MODE_ON) && (mode != MODE_OFF);
  end

  // owner powering up must bring every tile with it
  logic owner_up;
  assign owner_up = dom_sel_q[OWNER_DOM] && dom_st_q[OWNER_DOM] && !cur_i[OWNER_DOM];
  assign err_o    = (|tile_bad) || (owner_up && !(&tile_full));

  assert_no_write_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(dom_sel_q) && $stable(dom_st_q) && $stable(tile_sel_q) && $stable(tile_mode_q)));
endmodule

// File: rtl/pwr_order_pick.sv
module pwr_order_pick #(
  parameter int N_DOM  = 4,
  parameter int N_TILE = 6,
  localparam int N_SW  = N_DOM + N_TILE,
  localparam int IDX_W = $clog2(N_SW)
) (
  input  logic [N_SW-1:0]  cand_i,
  input  logic [N_SW-1:0]  tgt_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SW-1:0] dn, up;
  assign dn = cand_i & ~tgt_i;
  assign up = cand_i & tgt_i;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    if (|dn) begin
      valid_o = 1'b1;
      if (|dn[N_SW-1:N_DOM]) begin
        // lowest tile first
        for (int n = N_TILE - 1; n >= 0; n--)
          if (dn[N_DOM+n]) idx_o = IDX_W'(N_DOM + n);
      end else begin
        // deepest domain first
        for (int d = 0; d < N_DOM; d++)
          if (dn[d]) idx_o = IDX_W'(d);
      end
    end else if (|up) begin
      valid_o = 1'b1;
      // ascending index: domains top-down, then tiles
      for (int i = N_SW - 1; i >= 0; i--)
        if (up[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pwr_step_timer.sv
module pwr_step_timer #(
  parameter int TMO_CYC = 16,
  localparam int CNT_W  = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CNT_W'(TMO_CYC - 1));

  assert_cnt_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (int'(cnt_q) < TMO_CYC));
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
  import pwr_seq_pkg::*;
#(
  parameter int N_DOM     = 4,
  parameter int N_TILE    = 6,
  parameter int OWNER_DOM = 1,
  parameter int TMO_CYC   = 16,
  localparam int N_SW     = N_DOM + N_TILE,
  localparam int IDX_W    = $clog2(N_SW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic [N_SW-1:0]   ack_i,
  output logic [N_SW-1:0]   sw_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic [N_SW-1:0]  sw_en_q, pend_q, tgt_q;
  logic [IDX_W-1:0] cur_q;
  logic             busy_q, done_q, err_q;

  logic [N_SW-1:0]  req_sel, req_tgt, need_now, cand, tvec;
  logic             req_err, ack_hit, expire, step_done, start_acc, launch;
  logic             pick_v;
  logic [IDX_W-1:0] pick_idx;

  pwr_req_regs #(.N_DOM(N_DOM), .N_TILE(N_TILE), .OWNER_DOM(OWNER_DOM)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .busy_i(busy_q), .cur_i(sw_en_q),
    .sel_o(req_sel), .tgt_o(req_tgt), .err_o(req_err)
  );

  assign need_now  = req_sel & (req_tgt ^ sw_en_q);
  assign start_acc = start_i && !busy_q;
  assign ack_hit   = busy_q && (ack_i[cur_q] == sw_en_q[cur_q]);
  assign step_done = busy_q && (ack_hit || expire);
  assign launch    = (start_acc && !req_err) || step_done;
  assign cand      = start_acc ? need_now : pend_q;
  assign tvec      = start_acc ? req_tgt  : tgt_q;

  pwr_order_pick #(.N_DOM(N_DOM), .N_TILE(N_TILE)) u_pick (
    .cand_i(cand), .tgt_i(tvec), .valid_o(pick_v), .idx_o(pick_idx)
  );

  pwr_step_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk_i, .rst_ni, .clear_i(launch), .run_i(busy_q), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_en_q <= '0;
      pend_q  <= '0;
      tgt_q   <= '0;
      cur_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_acc && req_err) begin
        err_q  <= 1'b1;
        done_q <= 1'b1;
      end else if (launch) begin
        if (start_acc) begin
          err_q <= 1'b0;
          tgt_q <= req_tgt;
        end else if (!ack_hit) begin
          err_q <= 1'b1;
        end
        if (pick_v) begin
          sw_en_q[pick_idx] <= tvec[pick_idx];
          pend_q            <= cand & ~(N_SW'(1) << pick_idx);
          cur_q             <= pick_idx;
          busy_q            <= 1'b1;
        end else begin
          pend_q <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sw_en_o = sw_en_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  assert_one_switch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(sw_en_q ^ $past(sw_en_q)) <= 1));
  assert_idle_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(sw_en_q));
  assert_err_no_exec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && req_err) |=> (!busy_q && err_q && done_q && $stable(sw_en_q)));
  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

  localparam logic [N_SW-1:0] ONE_M  = N_SW'(1);
  localparam logic [N_SW-1:0] DOM_M  = (ONE_M << N_DOM) - ONE_M;
  localparam logic [N_SW-1:0] TILE_M = ~DOM_M;

  for (genvar i = 0; i < N_SW; i++) begin : g_order
    localparam logic [N_SW-1:0] BELOW = (ONE_M << i) - ONE_M;
    localparam logic [N_SW-1:0] SELF  = ONE_M << i;
    assert_up_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_en_q[i]) |-> !(|(pend_q & tgt_q & BELOW)));
    assert_dn_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sw_en_q[i]) |-> !(|(pend_q & ~tgt_q)));
    if (i < N_DOM) begin : g_dom
      assert_dn_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sw_en_q[i]) |-> !(|(pend_q & ~tgt_q & (TILE_M | (DOM_M & ~BELOW & ~SELF)))));
    end else begin : g_tile
      assert_dn_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sw_en_q[i]) |-> !(|(pend_q & ~tgt_q & TILE_M & BELOW)));
    end
  end
endmodule

// File: tb/tb_pwr_domain_seq.sv
`timescale 1ns/1ps
module tb_pwr_domain_seq;
  localparam int NSW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, start = 1'b0;
  logic [31:0] wr_data = '0;
  logic [NSW-1:0] ack, sw_en, stuck, s1, prev_sw;
  logic busy, done, err;

  int checks = 0, failures = 0, cyc = 0;
  int ev_idx[64];
  int ev_cyc[64];
  int ev_n = 0;
  bit busy_seen, done_seen;

  always #5 clk = ~clk;

  pwr_domain_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .start_i(start), .ack_i(ack),
    .sw_en_o(sw_en), .busy_o(busy), .done_o(done), .err_o(err)
  );

  // switch model: reports enable two registers later; stuck bits hold
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; ack <= '0;
    end else begin
      s1 <= sw_en;
      for (int i = 0; i < NSW; i++) if (!stuck[i]) ack[i] <= s1[i];
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NSW; i++)
        if (sw_en[i] !== prev_sw[i] && ev_n < 64) begin
          ev_idx[ev_n] = i; ev_cyc[ev_n] = cyc; ev_n++;
        end
      prev_sw = sw_en;
    end else prev_sw = '0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    ev_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    busy_seen = 0; done_seen = 0;
    for (int k = 0; k < 600; k++) begin
      if (busy) busy_seen = 1;
      if (done) begin done_seen = 1; break; end
      @(negedge clk);
    end
    check(done_seen, "R12 done pulse", int'(done_seen), 1);
    @(negedge clk);
    check(!done && !busy, "R12 done one cycle, idle", int'({done, busy}), 0);
  endtask

  task automatic check_seq(input string req, input int n, input int exp_idx[10], input int gap);
    check(ev_n == n, {req, " step count"}, ev_n, n);
    for (int k = 0; k < n && k < ev_n; k++) begin
      check(ev_idx[k] == exp_idx[k], {req, " step order"}, ev_idx[k], exp_idx[k]);
      if (gap > 0 && k > 0)
        check(ev_cyc[k] - ev_cyc[k-1] == gap, "R9 step spacing", ev_cyc[k] - ev_cyc[k-1], gap);
    end
  endtask

  task automatic t_reset();
    check(sw_en == '0 && !busy && !done && !err, "R12 reset state",
          int'({sw_en, busy, done, err}), 0);
  endtask

  // R2 R3 R6: domains 0..2 and all tiles up
  task automatic t_power_up();
    wr(1'b0, 32'h0700_0700);
    wr(1'b1, 32'h3F00_0FFF);
    pulse_start();
    check(busy, "R12 busy after start", int'(busy), 1);
    wait_done();
    check_seq("R6", 9, '{0,1,2,4,5,6,7,8,9,0}, 3);
    check(sw_en == 10'h3F7, "R6 final enables", sw_en, 10'h3F7);
    check(!err, "R12 no error", err, 0);
  endtask

  // R8 R9: mixed batch, d0 selected without change
  task automatic t_mixed();
    wr(1'b0, 32'h0D00_0900);
    wr(1'b1, 32'h1000_0000);
    pulse_start();
    wait_done();
    check_seq("R8", 3, '{8,2,3,0,0,0,0,0,0,0}, 3);
    check(sw_en == 10'h2FB, "R2 unselected kept", sw_en, 10'h2FB);
  endtask

  // R7: everything down
  task automatic t_all_down();
    wr(1'b0, 32'h0F00_0000);
    wr(1'b1, 32'h3F00_0000);
    pulse_start();
    wait_done();
    check_seq("R7", 8, '{4,5,6,7,9,3,1,0,0,0}, 3);
    check(sw_en == '0, "R7 final enables", sw_en, 0);
  endtask

  // R10 R3: refused requests
  task automatic t_tile_rule();
    wr(1'b0, 32'h0200_0200);
    wr(1'b1, 32'h3F00_0FDF);   // tile 2 mode 01
    pulse_start();
    wait_done();
    check(err && !busy_seen && ev_n == 0, "R3 invalid mode refused",
          int'({err, busy_seen}), 2);
    wr(1'b1, 32'h3700_0FFF);   // tile 3 not selected
    pulse_start();
    wait_done();
    check(err && !busy_seen && ev_n == 0, "R10 owner without tiles refused",
          int'({err, busy_seen}), 2);
    check(sw_en == '0, "R10 enables unchanged", sw_en, 0);
  endtask

  // R9 R12: empty batch finishes at once and clears error
  task automatic t_empty();
    wr(1'b0, 32'h0000_0000);
    wr(1'b1, 32'h0000_0000);
    pulse_start();
    wait_done();
    check(!busy_seen && ev_n == 0, "R9 empty batch no steps", ev_n, 0);
    check(!err, "R12 error cleared on start", err, 0);
  endtask

  // R11: stuck acknowledge on switch 0
  task automatic t_timeout();
    stuck = 10'h001;
    wr(1'b0, 32'h0500_0500);
    wr(1'b1, 32'h0000_0000);
    pulse_start();
    wait_done();
    check_seq("R11", 2, '{0,2,0,0,0,0,0,0,0,0}, 0);
    if (ev_n == 2) check(ev_cyc[1] - ev_cyc[0] == 16, "R11 timeout spacing", ev_cyc[1] - ev_cyc[0], 16);
    check(err, "R11 error on timeout", err, 1);
    check(sw_en == 10'h005, "R11 final enables", sw_en, 10'h005);
    stuck = '0;
    repeat (4) @(negedge clk);
  endtask

  // R1 R4: start and write while busy ignored
  task automatic t_busy_ignore();
    wr(1'b0, 32'h0800_0800);
    wr(1'b1, 32'h3F00_0FFF);
    pulse_start();
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h0100_0000;
    @(negedge clk); wr_en = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    check_seq("R4", 7, '{3,4,5,6,7,8,9,0,0,0}, 3);
    check(sw_en == 10'h3FD, "R4 final enables", sw_en, 10'h3FD);
    pulse_start();
    wait_done();
    check(ev_n == 0 && sw_en == 10'h3FD, "R1 busy write dropped", sw_en, 10'h3FD);
  endtask

  initial begin
    stuck = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_power_up();
    t_mixed();
    t_all_down();
    t_tile_rule();
    t_empty();
    t_timeout();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule